// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block guesses the next result that an instruction will produce. It keeps a small direct-mapped table indexed by the instruction's PC. Each entry holds four things: the most recent result, a committed stride used to form predictions, the stride seen on the latest update, and a tag. A lookup returns the stored last value plus the committed stride, together with a flag that says whether the entry belongs to the PC that asked.

When an instruction retires, the update port receives its PC and its actual result. On a tag match the entry is retrained. The difference between the new result and the stored last value becomes the newest observed stride. The committed stride takes that difference only when it repeats the previously observed stride. This two-step confirmation means one outlying result cannot disturb a steady stride. On a tag mismatch the entry is taken over for the new PC.

The block handles one lookup and one update per cycle. Lookups are combinational reads of the table. Updates are written at the clock edge.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every entry is empty: any lookup reports pred_hit = 0 and pred_value = 0 until that entry is written by an update.
- R2: pred_valid follows lkp_valid in the same cycle. pred_hit is 0 whenever lkp_valid is 0. pred_value is 0 whenever pred_hit is 0.
- R3: An update whose PC misses the tag allocates the entry: last value = actual value, both strides = 0. A following lookup of that PC hits and predicts the actual value.
- R4: On an update that hits, the newly seen stride is the actual value minus the stored last value. The last value and the observed stride are always overwritten with the new value and the new stride.
- R5: The committed stride is replaced by the new stride only when the new stride equals the stored observed stride. Otherwise the committed stride keeps its value.
- R6: A single outlying value within a run of constant stride leaves the committed stride unchanged. The prediction is the outlier plus the old stride, and after the run resumes it is the newest value plus the old stride.
- R7: The entry index is PC bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS] and the tag is every PC bit above them. Two PCs with the same index and different tags evict each other.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R9: Stride and prediction arithmetic wrap modulo 2^VAL_W, so negative strides and overflow past the top of the value range predict correctly.
- R10: PC bits below ALIGN_BITS do not affect the index or the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_pc | input | PC_W | PC being looked up |
| pred_valid | output | 1 | Lookup response present |
| pred_hit | output | 1 | Entry belongs to lkp_pc |
| pred_value | output | VAL_W | Predicted result (last value + committed stride), 0 on miss |
| upd_valid | input | 1 | Update request this cycle |
| upd_pc | input | PC_W | PC of the retiring instruction |
| upd_value | input | VAL_W | Actual result of the retiring instruction |

## Verification
The predictor is driven with several value streams, and each one separates a different behaviour:
- A rising run of constant stride shows how many updates are needed before the committed stride takes hold.
- A run interrupted by one large outlier distinguishes two-step confirmation from last-stride training.
- A deliberate stride change checks that a repeated new stride is adopted.
- A descending run and a run that crosses the top of the value range expose sign or overflow errors in the stride subtraction.
- PC pairs sharing an index but not a tag, and PCs that differ only in the alignment bits, tell the index/tag split apart from a wrong bit slice.
- A lookup issued together with an update to the same entry confirms that the lookup reads the old contents.

// File: rtl/svp_pkg.sv
package svp_pkg;
   typedef enum logic [1:0] {
      TRN_ALLOC   = 2'd0,
      TRN_CONFIRM = 2'd1,
      TRN_HOLD    = 2'd2
   } trn_kind_e;
endpackage

// File: rtl/svp_pc_split.sv
module svp_pc_split #(
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2,
   parameter int IDX_W      = 4,
   localparam int TAG_W     = PC_W - ALIGN_BITS - IDX_W
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   assign idx = pc[ALIGN_BITS +: IDX_W];
   assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/svp_table.sv
module svp_table #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int VAL_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   // read port A (lookup)
   input  logic [IDX_W-1:0] ra_idx,
   output logic             ra_vld,
   output logic [TAG_W-1:0] ra_tag,
   output logic [VAL_W-1:0] ra_last,
   output logic [VAL_W-1:0] ra_pstr,
   // read port B (update side)
   input  logic [IDX_W-1:0] rb_idx,
   output logic             rb_vld,
   output logic [TAG_W-1:0] rb_tag,
   output logic [VAL_W-1:0] rb_last,
   output logic [VAL_W-1:0] rb_pstr,
   output logic [VAL_W-1:0] rb_obs,
   // write port
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [VAL_W-1:0] wr_last,
   input  logic [VAL_W-1:0] wr_pstr,
   input  logic [VAL_W-1:0] wr_obs
);
   logic             vld_a  [ENTRIES];
   logic [TAG_W-1:0] tag_a  [ENTRIES];
   logic [VAL_W-1:0] last_a [ENTRIES];
   logic [VAL_W-1:0] pstr_a [ENTRIES];
   logic [VAL_W-1:0] obs_a  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [VAL_W-1:0] l_q, p_q, o_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   v_q <= 1'b0;
         else if (sel) v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            t_q <= wr_tag;
            l_q <= wr_last;
            p_q <= wr_pstr;
            o_q <= wr_obs;
         end
      end

      assign vld_a[e]  = v_q;
      assign tag_a[e]  = t_q;
      assign last_a[e] = l_q;
      assign pstr_a[e] = p_q;
      assign obs_a[e]  = o_q;
   end

   assign ra_vld  = vld_a[ra_idx];
   assign ra_tag  = tag_a[ra_idx];
   assign ra_last = last_a[ra_idx];
   assign ra_pstr = pstr_a[ra_idx];

   assign rb_vld  = vld_a[rb_idx];
   assign rb_tag  = tag_a[rb_idx];
   assign rb_last = last_a[rb_idx];
   assign rb_pstr = pstr_a[rb_idx];
   assign rb_obs  = obs_a[rb_idx];
endmodule

// File: rtl/svp_trainer.sv
module svp_trainer
   import svp_pkg::*;
#(
   parameter int VAL_W = 32
) (
   input  logic             hit,
   input  logic [VAL_W-1:0] old_last,
   input  logic [VAL_W-1:0] old_pstr,
   input  logic [VAL_W-1:0] old_obs,
   input  logic [VAL_W-1:0] actual,
   output logic [VAL_W-1:0] nxt_last,
   output logic [VAL_W-1:0] nxt_pstr,
   output logic [VAL_W-1:0] nxt_obs,
   output trn_kind_e        kind
);
   logic [VAL_W-1:0] seen_stride;

   assign seen_stride = actual - old_last;

   always_comb begin
      nxt_last = actual;
      if (!hit) begin
         kind     = TRN_ALLOC;
         nxt_pstr = '0;
         nxt_obs  = '0;
      end else begin
         nxt_obs = seen_stride;
         if (seen_stride == old_obs) begin
            kind     = TRN_CONFIRM;
            nxt_pstr = seen_stride;
         end else begin
            kind     = TRN_HOLD;
            nxt_pstr = old_pstr;
         end
      end
   end
endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor
   import svp_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int VAL_W      = 32,
   parameter int ENTRIES    = 16,
   parameter int ALIGN_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lkp_valid,
   input  logic [PC_W-1:0]  lkp_pc,
   output logic             pred_valid,
   output logic             pred_hit,
   output logic [VAL_W-1:0] pred_value,
   input  logic             upd_valid,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic [VAL_W-1:0] upd_value
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = PC_W - ALIGN_BITS - IDX_W;

   if (ENTRIES < 2 || ENTRIES != (1 << IDX_W)) begin : g_bad_depth
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("PC_W too small for ENTRIES and ALIGN_BITS");
   end
   if (VAL_W < 1) begin : g_bad_val
      $error("VAL_W must be positive");
   end

   logic [IDX_W-1:0] l_idx, u_idx;
   logic [TAG_W-1:0] l_tag, u_tag;

   svp_pc_split #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)) u_split_lkp (
      .pc(lkp_pc), .idx(l_idx), .tag(l_tag)
   );
   svp_pc_split #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)) u_split_upd (
      .pc(upd_pc), .idx(u_idx), .tag(u_tag)
   );

   logic             a_vld, b_vld;
   logic [TAG_W-1:0] a_tag, b_tag;
   logic [VAL_W-1:0] a_last, a_pstr;
   logic [VAL_W-1:0] u_old_last, u_old_pstr, u_old_obs;
   logic [VAL_W-1:0] w_last, w_pstr, w_obs;
   logic             upd_hit;
   trn_kind_e        trn_kind;

   svp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (l_idx),
      .ra_vld  (a_vld),
      .ra_tag  (a_tag),
      .ra_last (a_last),
      .ra_pstr (a_pstr),
      .rb_idx  (u_idx),
      .rb_vld  (b_vld),
      .rb_tag  (b_tag),
      .rb_last (u_old_last),
      .rb_pstr (u_old_pstr),
      .rb_obs  (u_old_obs),
      .wr_en   (upd_valid),
      .wr_idx  (u_idx),
      .wr_tag  (u_tag),
      .wr_last (w_last),
      .wr_pstr (w_pstr),
      .wr_obs  (w_obs)
   );

   assign upd_hit = b_vld && (b_tag == u_tag);

   svp_trainer #(.VAL_W(VAL_W)) u_trainer (
      .hit      (upd_hit),
      .old_last (u_old_last),
      .old_pstr (u_old_pstr),
      .old_obs  (u_old_obs),
      .actual   (upd_value),
      .nxt_last (w_last),
      .nxt_pstr (w_pstr),
      .nxt_obs  (w_obs),
      .kind     (trn_kind)
   );

   logic lkp_match;
   assign lkp_match  = lkp_valid && a_vld && (a_tag == l_tag);
   assign pred_valid = lkp_valid;
   assign pred_hit   = lkp_match;
   assign pred_value = lkp_match ? (a_last + a_pstr) : '0;
endmodule

// File: rtl/svp_checker.sv
module svp_checker #(
   parameter int PC_W  = 32,
   parameter int VAL_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lkp_valid,
   input logic [PC_W-1:0]  lkp_pc,
   input logic             pred_hit,
   input logic [VAL_W-1:0] pred_value,
   input logic             upd_valid,
   input logic [PC_W-1:0]  upd_pc,
   input logic [VAL_W-1:0] upd_value,
   input logic             upd_hit,
   input logic [VAL_W-1:0] u_old_last,
   input logic [VAL_W-1:0] u_old_obs
);
   // R1: first cycle out of reset sees an empty table
   p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pred_hit);

   // R2: no hit without a lookup
   p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |-> !pred_hit);

   // R2: a miss carries a zero prediction
   p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> pred_value == '0);

   // R3: an allocation is visible on the next lookup of that PC
   p_alloc_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_valid && $past(upd_valid) && !$past(upd_hit) && lkp_pc == $past(upd_pc))
      |-> (pred_hit && pred_value == $past(upd_value)));

   // R5: a repeated stride becomes the committed stride
   p_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_valid && $past(upd_valid) && $past(upd_hit) && lkp_pc == $past(upd_pc)
       && ($past(upd_value) - $past(u_old_last)) == $past(u_old_obs))
      |-> (pred_hit && pred_value == $past(upd_value) + $past(u_old_obs)));
endmodule

bind stride_value_predictor svp_checker #(.PC_W(PC_W), .VAL_W(VAL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lkp_valid  (lkp_valid),
   .lkp_pc     (lkp_pc),
   .pred_hit   (pred_hit),
   .pred_value (pred_value),
   .upd_valid  (upd_valid),
   .upd_pc     (upd_pc),
   .upd_value  (upd_value),
   .upd_hit    (upd_hit),
   .u_old_last (u_old_last),
   .u_old_obs  (u_old_obs)
);

// File: tb/sim_stride_value_predictor.sv
`timescale 1ns/1ps
module sim_stride_value_predictor;
   localparam int PC_W  = 32;
   localparam int VAL_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lkp_valid = 1'b0;
   logic [PC_W-1:0]  lkp_pc = '0;
   logic             pred_valid, pred_hit;
   logic [VAL_W-1:0] pred_value;
   logic             upd_valid = 1'b0;
   logic [PC_W-1:0]  upd_pc = '0;
   logic [VAL_W-1:0] upd_value = '0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stride_value_predictor #(.PC_W(PC_W), .VAL_W(VAL_W), .ENTRIES(16), .ALIGN_BITS(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
      .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_value(pred_value),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_value(upd_value)
   );

   task automatic chk(input string req, input logic [VAL_W:0] act, input logic [VAL_W:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // writes at the next rising edge, leaves inputs idle 1 ns after it
   task automatic upd(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] v);
      upd_valid = 1'b1; upd_pc = pc; upd_value = v;
      @(posedge clk); #1;
      upd_valid = 1'b0;
   endtask

   // combinational lookup, sampled mid-cycle
   task automatic look(input string req, input logic [PC_W-1:0] pc,
                       input logic hit, input logic [VAL_W-1:0] v);
      lkp_valid = 1'b1; lkp_pc = pc;
      #2;
      chk(req, {pred_valid, pred_value}, {1'b1, v});
      chk(req, {{VAL_W{1'b0}}, pred_hit}, {{VAL_W{1'b0}}, hit});
      lkp_valid = 1'b0;
   endtask

   task automatic t_reset;
      look("R1", 32'h0000_0100, 1'b0, '0);
      look("R1", 32'hFFFF_FFFC, 1'b0, '0);
   endtask

   task automatic t_train;          // PC 0x100, rising stride 10
      upd(32'h100, 100); look("R3", 32'h100, 1'b1, 100);
      upd(32'h100, 110); look("R5", 32'h100, 1'b1, 110);  // one sighting: no commit
      upd(32'h100, 120); look("R4", 32'h100, 1'b1, 130);  // confirmed
      upd(32'h100, 130); look("R4", 32'h100, 1'b1, 140);
   endtask

   task automatic t_stray;
      upd(32'h100, 500); look("R6", 32'h100, 1'b1, 510);
      upd(32'h100, 510); look("R6", 32'h100, 1'b1, 520);
      upd(32'h100, 520); look("R6", 32'h100, 1'b1, 530);
   endtask

   task automatic t_change;         // stride 10 -> 20 needs two sightings
      upd(32'h100, 540); look("R5", 32'h100, 1'b1, 550);
      upd(32'h100, 560); look("R5", 32'h100, 1'b1, 580);
   endtask

   task automatic t_wrap;
      upd(32'h104, 32'hFFFF_FFF0);
      upd(32'h104, 32'hFFFF_FFF8);
      upd(32'h104, 32'h0000_0000);
      look("R9", 32'h104, 1'b1, 32'h8);
      upd(32'h10C, 100); upd(32'h10C, 90); upd(32'h10C, 80);
      look("R9", 32'h10C, 1'b1, 70);
   endtask

   task automatic t_alias;          // 0x140 shares index 0 with 0x100
      upd(32'h140, 7);
      look("R7", 32'h100, 1'b0, '0);
      look("R7", 32'h140, 1'b1, 7);
      look("R10", 32'h143, 1'b1, 7);
      look("R10", 32'h141, 1'b1, 7);
   endtask

   task automatic t_same_cycle;     // PC 0x208, index 2
      upd(32'h208, 50);
      upd_valid = 1'b1; upd_pc = 32'h208; upd_value = 60;
      lkp_valid = 1'b1; lkp_pc = 32'h208;
      #2;
      chk("R8", {pred_hit, pred_value}, {1'b1, 32'd50});
      @(posedge clk); #1;
      upd_valid = 1'b0; lkp_valid = 1'b0;
      look("R8", 32'h208, 1'b1, 60);
   endtask

   task automatic t_idle;
      lkp_valid = 1'b0; lkp_pc = 32'h208;
      #2;
      chk("R2", {pred_valid, pred_hit}, 2'b00);
      chk("R2", pred_value, '0);
   endtask

   initial begin
      #23 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_train();
      t_stray();
      t_change();
      t_wrap();
      t_alias();
      t_same_cycle();
      t_idle();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule